// File: doc/BRIEF.md
# Serial Flash Identification and Geometry Probe

This block runs once after every reset. It finds out which page-organised serial flash sits on its SPI port and reports the geometry that the rest of the chip needs to address it: page size in bytes, page-address shift, page count, and whether the part is running with power-of-two pages. It acts as the SPI master itself. It uses mode 0, sends the most significant bit first, and drives its own chip select.

The probe is one fixed sequence of two transactions. The first is a standard identification read, which returns a vendor byte and a two-byte device code. Chip select then stays high for a configurable number of cycles. The second transaction reads the status byte. If the vendor byte is the expected one, the device code selects a table entry. Bit 0 of the status byte then chooses between the power-of-two page size and the extended page size, for the parts that offer both.

Any other vendor byte means the part is an older one without identification support. In that case the density code carried in the status byte decides the geometry. At the end exactly one of three sticky flags is raised: a valid geometry, an unsupported device, or no device present. The flag stays set until the next reset.

Top module: `flash_geom_probe`

## Requirements
- R1: After reset is released the block lowers `spi_cs_n` and sends opcode 0x9F in SPI mode 0, MSB first. It then clocks in three bytes in this order: vendor, device-code high, device-code low. `spi_sclk` stays low whenever `spi_cs_n` is high.
- R2: After the identification read, `spi_cs_n` stays high for at least `CS_GAP` clock cycles. The block then sends opcode 0xD7 and clocks in one status byte. No further transaction follows.
- R3: When the vendor byte is 0x1F, the 16-bit device code sets the page count: 0x2200→512, 0x2300→1024, 0x2400→2048, 0x2500→4096, 0x2600→4096, 0x2700→8192, 0x2701→8192, 0x2800→8192.
- R4: For the identified parts that offer a binary page size, status bit 0 = 1 selects size 2^s and shift s. Status bit 0 = 0 selects size 2^s + 2^(s-5) and shift s+1. The value of s is 8 for codes 0x2200–0x2500, 9 for 0x2600 and 0x2701, and 10 for 0x2800. `binary_pages` equals the chosen mode.
- R5: Device code 0x2700 with vendor 0x1F always reports 528-byte pages, shift 10 and `binary_pages` = 0, whatever the status bit 0.
- R6: When the vendor byte is not 0x1F and the status byte is 0x00 or 0xFF, the block raises `res_absent`.
- R7: When the vendor byte is not 0x1F and the status byte is neither 0x00 nor 0xFF, status bits 5:2 (mask 0x3C) decide the geometry, and `binary_pages` is 0. The codes are: 0x0C→512×264, 0x14→1024×264, 0x1C→2048×264, 0x24→4096×264, 0x2C→4096×528, 0x34→8192×528, 0x38 and 0x3C→8192×1056. The shift is 9 for 264-byte pages, 10 for 528 and 11 for 1056.
- R8: An unlisted device code with vendor 0x1F, or any other masked density code in the fallback path, raises `res_unsupported`.
- R9: After the probe, exactly one of `res_valid`, `res_unsupported` and `res_absent` is 1. The flags and the geometry stay constant and no more SPI traffic occurs until the next reset.
- R10: While `rst_n` is low, and before a result, all result outputs are 0 and `spi_cs_n` is 1. Geometry outputs are 0 unless `res_valid` is 1. A reset in the middle of a probe abandons it and starts a fresh probe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset; release starts a probe |
| spi_sclk | output | 1 | SPI serial clock, idles low |
| spi_mosi | output | 1 | SPI data to the flash |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_miso | input | 1 | SPI data from the flash |
| res_valid | output | 1 | Geometry outputs hold a recognised device |
| res_unsupported | output | 1 | A device answered but its code is not recognised |
| res_absent | output | 1 | No device answered |
| page_count | output | 14 | Number of pages |
| page_size | output | 11 | Bytes per page |
| page_shift | output | 4 | Bit position of the page number in a flash address |
| binary_pages | output | 1 | 1 when the page size is a power of two |

## Verification
The assertions take for granted that the attached flash behaves as a mode-0 device. It changes `spi_miso` only after a falling `spi_sclk` edge, so the line is stable at every rising edge. They also assume reset is held for at least one clock edge. The bench's flash model updates its data line only on falling clock edges and decodes the opcode from the rising-edge samples. It replies only with the programmed vendor, device and status bytes. Every probe therefore stays inside the timing and protocol the block expects.

// File: rtl/fprobe_pkg.sv
// Shared widths, opcodes and types for the flash geometry probe.
// Assumes page counts up to 8192 and page sizes up to 1056 bytes.
package fprobe_pkg;
    localparam int PCNT_W   = 14;
    localparam int PSIZE_W  = 11;
    localparam int PSHIFT_W = 4;
    localparam int LOG_W    = 4;

    localparam logic [7:0] VENDOR_ID  = 8'h1F;
    localparam logic [7:0] OP_READ_ID = 8'h9F;
    localparam logic [7:0] OP_STATUS  = 8'hD7;

    typedef enum logic [1:0] {
        GK_OK     = 2'd0,
        GK_UNSUP  = 2'd1,
        GK_ABSENT = 2'd2
    } geom_kind_e;

    typedef struct packed {
        geom_kind_e            kind;
        logic [PCNT_W-1:0]     count;
        logic [PSIZE_W-1:0]    size;
        logic [PSHIFT_W-1:0]   shift;
        logic                  binary;
    } geom_t;

    // Compact description of one density class: log2 of page count,
    // log2 of the binary page size, and whether binary mode exists.
    typedef struct packed {
        logic                  hit;
        logic [LOG_W-1:0]      cnt_log;
        logic [PSHIFT_W-1:0]   bshift;
        logic                  has_bin;
    } shape_t;

    typedef enum logic [2:0] {
        SQ_ID_OP,
        SQ_ID_RD,
        SQ_GAP,
        SQ_SR_OP,
        SQ_SR_RD,
        SQ_DECIDE,
        SQ_DONE
    } seq_state_e;
endpackage

// File: rtl/fprobe_spi_byte.sv
// One-byte SPI mode-0 shifter. A start pulse loads tx_byte and runs eight
// clocks, MSB first. MISO is sampled on each rising sclk and MOSI advances on
// each falling sclk. done pulses for one cycle after the eighth falling edge,
// and rx_byte is then valid. Assumes start arrives only while busy is low.
module fprobe_spi_byte #(
    parameter int SCLK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi
);
    localparam int HCW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam logic [HCW-1:0] HC_LAST = HCW'(SCLK_HALF - 1);

    logic [HCW-1:0] hcnt;
    logic [2:0]     bcnt;
    logic [7:0]     shreg;

    assign mosi = shreg[7];

    // Half-period timing, bit counting and both shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            sclk    <= 1'b0;
            hcnt    <= '0;
            bcnt    <= '0;
            shreg   <= '0;
            rx_byte <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    shreg <= tx_byte;
                    hcnt  <= '0;
                    bcnt  <= '0;
                    sclk  <= 1'b0;
                end
            end else if (hcnt == HC_LAST) begin
                hcnt <= '0;
                sclk <= ~sclk;
                if (!sclk) begin
                    rx_byte <= {rx_byte[6:0], miso};
                end else begin
                    shreg <= {shreg[6:0], 1'b0};
                    bcnt  <= bcnt + 3'd1;
                    if (bcnt == 3'd7) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end
            end else begin
                hcnt <= hcnt + HCW'(1);
            end
        end
    end
endmodule

// File: rtl/fprobe_geom_decode.sv
// Combinational geometry decoder. It takes the three identification bytes
// and the status byte and works out the device class and its geometry. The
// identification table is used when the vendor byte matches; otherwise the
// legacy density code in status bits 5:2 is used. Page sizes are derived
// from the binary size: extended = binary + binary/32.
module fprobe_geom_decode
    import fprobe_pkg::*;
(
    input  logic [7:0] id_vendor,
    input  logic [7:0] id_dev_hi,
    input  logic [7:0] id_dev_lo,
    input  logic [7:0] status,
    output geom_t      geom
);
    function automatic shape_t mk(input logic [LOG_W-1:0] c,
                                  input logic [PSHIFT_W-1:0] b,
                                  input logic hb);
        shape_t s;
        s.hit     = 1'b1;
        s.cnt_log = c;
        s.bshift  = b;
        s.has_bin = hb;
        return s;
    endfunction

    function automatic shape_t id_shape(input logic [15:0] dev);
        shape_t s;
        case (dev)
            16'h2200: s = mk(4'd9,  4'd8,  1'b1);
            16'h2300: s = mk(4'd10, 4'd8,  1'b1);
            16'h2400: s = mk(4'd11, 4'd8,  1'b1);
            16'h2500: s = mk(4'd12, 4'd8,  1'b1);
            16'h2600: s = mk(4'd12, 4'd9,  1'b1);
            16'h2700: s = mk(4'd13, 4'd9,  1'b0);
            16'h2701: s = mk(4'd13, 4'd9,  1'b1);
            16'h2800: s = mk(4'd13, 4'd10, 1'b1);
            default:  s = '0;
        endcase
        return s;
    endfunction

    function automatic shape_t legacy_shape(input logic [3:0] code);
        shape_t s;
        case (code)
            4'h3:        s = mk(4'd9,  4'd8,  1'b0);
            4'h5:        s = mk(4'd10, 4'd8,  1'b0);
            4'h7:        s = mk(4'd11, 4'd8,  1'b0);
            4'h9:        s = mk(4'd12, 4'd8,  1'b0);
            4'hB:        s = mk(4'd12, 4'd9,  1'b0);
            4'hD:        s = mk(4'd13, 4'd9,  1'b0);
            4'hE, 4'hF:  s = mk(4'd13, 4'd10, 1'b0);
            default:     s = '0;
        endcase
        return s;
    endfunction

    shape_t               shp;
    logic                 vendor_ok;
    logic                 absent;
    logic                 use_bin;
    logic [PSIZE_W-1:0]   base_size;

    // Pick the shape source, then expand it into the geometry result.
    always_comb begin
        vendor_ok = (id_vendor == VENDOR_ID);
        absent    = !vendor_ok && ((status == 8'h00) || (status == 8'hFF));
        shp       = vendor_ok ? id_shape({id_dev_hi, id_dev_lo})
                              : legacy_shape(status[5:2]);
        use_bin   = vendor_ok && shp.has_bin && status[0];
        base_size = PSIZE_W'(1) << shp.bshift;
        geom      = '0;
        if (absent) begin
            geom.kind = GK_ABSENT;
        end else if (shp.hit) begin
            geom.kind   = GK_OK;
            geom.count  = PCNT_W'(1) << shp.cnt_log;
            geom.size   = use_bin ? base_size : base_size + (base_size >> 5);
            geom.shift  = use_bin ? shp.bshift : shp.bshift + PSHIFT_W'(1);
            geom.binary = use_bin;
        end else begin
            geom.kind = GK_UNSUP;
        end
    end
endmodule

// File: rtl/fprobe_seq.sv
// Probe sequencer. It runs the identification read (opcode plus three reply
// bytes), holds chip select high for CS_GAP cycles, then runs the status read
// (opcode plus one byte). It pulses decide once and parks until reset. It
// assumes the byte shifter accepts a start only when it is idle.
module fprobe_seq
    import fprobe_pkg::*;
#(
    parameter int CS_GAP = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       eng_done,
    input  logic [7:0] eng_rx,
    output logic       eng_start,
    output logic [7:0] eng_tx,
    output logic       cs_n,
    output logic [7:0] id_vendor,
    output logic [7:0] id_dev_hi,
    output logic [7:0] id_dev_lo,
    output logic [7:0] status,
    output logic       decide
);
    localparam int GW = $clog2(CS_GAP + 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(CS_GAP - 1);

    seq_state_e      state;
    logic            issued;
    logic [1:0]      byte_idx;
    logic [GW-1:0]   gcnt;

    // Walk the fixed two-transaction probe and capture the reply bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_ID_OP;
            cs_n      <= 1'b1;
            issued    <= 1'b0;
            eng_start <= 1'b0;
            eng_tx    <= '0;
            byte_idx  <= '0;
            gcnt      <= '0;
            id_vendor <= '0;
            id_dev_hi <= '0;
            id_dev_lo <= '0;
            status    <= '0;
            decide    <= 1'b0;
        end else begin
            eng_start <= 1'b0;
            decide    <= 1'b0;
            case (state)
                SQ_ID_OP, SQ_ID_RD, SQ_SR_OP, SQ_SR_RD: begin
                    if (cs_n) begin
                        cs_n <= 1'b0;
                    end else if (!issued) begin
                        eng_start <= 1'b1;
                        issued    <= 1'b1;
                        eng_tx    <= (state == SQ_ID_OP) ? OP_READ_ID :
                                     (state == SQ_SR_OP) ? OP_STATUS  : 8'h00;
                    end else if (eng_done) begin
                        issued <= 1'b0;
                        if (state == SQ_ID_OP) begin
                            state    <= SQ_ID_RD;
                            byte_idx <= '0;
                        end else if (state == SQ_ID_RD) begin
                            if (byte_idx == 2'd0) id_vendor <= eng_rx;
                            if (byte_idx == 2'd1) id_dev_hi <= eng_rx;
                            if (byte_idx == 2'd2) begin
                                id_dev_lo <= eng_rx;
                                cs_n      <= 1'b1;
                                gcnt      <= '0;
                                state     <= SQ_GAP;
                            end else begin
                                byte_idx <= byte_idx + 2'd1;
                            end
                        end else if (state == SQ_SR_OP) begin
                            state <= SQ_SR_RD;
                        end else begin
                            status <= eng_rx;
                            cs_n   <= 1'b1;
                            state  <= SQ_DECIDE;
                        end
                    end
                end
                SQ_GAP: begin
                    if (gcnt == GAP_LAST) state <= SQ_SR_OP;
                    else                  gcnt  <= gcnt + GW'(1);
                end
                SQ_DECIDE: begin
                    decide <= 1'b1;
                    state  <= SQ_DONE;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/flash_geom_probe.sv
// Top of the flash geometry probe. It connects the sequencer, the SPI byte
// shifter and the decoder, and latches the decoded result once per reset.
// Assumes a mode-0 flash on the SPI pins; SCLK_HALF sets the serial clock
// half period in clk cycles and CS_GAP the deselect time between reads.
module flash_geom_probe
    import fprobe_pkg::*;
#(
    parameter int SCLK_HALF = 2,
    parameter int CS_GAP    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic                spi_sclk,
    output logic                spi_mosi,
    output logic                spi_cs_n,
    input  logic                spi_miso,
    output logic                res_valid,
    output logic                res_unsupported,
    output logic                res_absent,
    output logic [PCNT_W-1:0]   page_count,
    output logic [PSIZE_W-1:0]  page_size,
    output logic [PSHIFT_W-1:0] page_shift,
    output logic                binary_pages
);
    logic       eng_start, eng_busy, eng_done;
    logic [7:0] eng_tx, eng_rx;
    logic [7:0] id_vendor, id_dev_hi, id_dev_lo, status;
    logic       decide;
    geom_t      geom;

    fprobe_seq #(.CS_GAP(CS_GAP)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .eng_done  (eng_done),
        .eng_rx    (eng_rx),
        .eng_start (eng_start),
        .eng_tx    (eng_tx),
        .cs_n      (spi_cs_n),
        .id_vendor (id_vendor),
        .id_dev_hi (id_dev_hi),
        .id_dev_lo (id_dev_lo),
        .status    (status),
        .decide    (decide)
    );

    fprobe_spi_byte #(.SCLK_HALF(SCLK_HALF)) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_start),
        .tx_byte (eng_tx),
        .miso    (spi_miso),
        .busy    (eng_busy),
        .done    (eng_done),
        .rx_byte (eng_rx),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi)
    );

    fprobe_geom_decode dec_i (
        .id_vendor (id_vendor),
        .id_dev_hi (id_dev_hi),
        .id_dev_lo (id_dev_lo),
        .status    (status),
        .geom      (geom)
    );

    logic eng_busy_unused;
    assign eng_busy_unused = eng_busy;

    // Latch the decoded result on the single decide pulse of this reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid       <= 1'b0;
            res_unsupported <= 1'b0;
            res_absent      <= 1'b0;
            page_count      <= '0;
            page_size       <= '0;
            page_shift      <= '0;
            binary_pages    <= 1'b0;
        end else if (decide) begin
            res_valid       <= (geom.kind == GK_OK);
            res_unsupported <= (geom.kind == GK_UNSUP);
            res_absent      <= (geom.kind == GK_ABSENT);
            if (geom.kind == GK_OK) begin
                page_count   <= geom.count;
                page_size    <= geom.size;
                page_shift   <= geom.shift;
                binary_pages <= geom.binary;
            end
        end
    end
endmodule

// File: rtl/fprobe_chk.sv
// Assertion checker for flash_geom_probe, attached by bind. It assumes a
// mode-0 flash that changes MISO only after falling sclk edges.
module fprobe_chk
    import fprobe_pkg::*;
#(
    parameter int CS_GAP = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                spi_sclk,
    input logic                spi_cs_n,
    input logic                res_valid,
    input logic                res_unsupported,
    input logic                res_absent,
    input logic [PCNT_W-1:0]   page_count,
    input logic [PSIZE_W-1:0]  page_size,
    input logic [PSHIFT_W-1:0] page_shift,
    input logic                binary_pages
);
    localparam int HW = $clog2(CS_GAP + 1);
    localparam logic [HW-1:0] HI_SAT = HW'(CS_GAP);

    logic [HW-1:0] hi_cnt;
    logic          seen_low;
    logic          finished;

    assign finished = res_valid | res_unsupported | res_absent;

    // Count consecutive deselected cycles, saturating at CS_GAP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt   <= '0;
            seen_low <= 1'b0;
        end else if (spi_cs_n) begin
            if (hi_cnt != HI_SAT) hi_cnt <= hi_cnt + HW'(1);
        end else begin
            hi_cnt   <= '0;
            seen_low <= 1'b1;
        end
    end

    p_sclk_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    p_cs_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_low && $fell(spi_cs_n)) |-> (hi_cnt >= HI_SAT));

    p_count_pow2_r3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $onehot(page_count));

    p_binary_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && binary_pages) |-> (page_size == (PSIZE_W'(1) << page_shift)));

    p_ext_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !binary_pages) |->
        (page_size == ((PSIZE_W'(1) << (page_shift - 4'd1)) +
                       (PSIZE_W'(1) << (page_shift - 4'd6)))));

    p_result_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_valid, res_unsupported, res_absent}));

    p_result_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        finished |=> $stable({res_valid, res_unsupported, res_absent,
                              page_count, page_size, page_shift, binary_pages}));

    p_idle_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        finished |-> (spi_cs_n && !spi_sclk));

    p_geom_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (page_count == '0 && page_size == '0 &&
                        page_shift == '0 && !binary_pages));
endmodule

bind flash_geom_probe fprobe_chk #(.CS_GAP(CS_GAP)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .spi_sclk        (spi_sclk),
    .spi_cs_n        (spi_cs_n),
    .res_valid       (res_valid),
    .res_unsupported (res_unsupported),
    .res_absent      (res_absent),
    .page_count      (page_count),
    .page_size       (page_size),
    .page_shift      (page_shift),
    .binary_pages    (binary_pages)
);

// File: tb/flash_geom_probe_tb_top.sv
`timescale 1ns/1ps
// Bench for flash_geom_probe: a behavioural mode-0 flash model, a vector
// table walked by one loop, then directed reset and persistence tests.
module flash_geom_probe_tb_top;
    localparam int SCLK_HALF = 2;
    localparam int CS_GAP    = 4;

    // kind: 0 = valid, 1 = unsupported, 2 = absent
    typedef struct packed {
        logic [7:0]  vendor;
        logic [15:0] dev;
        logic [7:0]  st;
        logic [1:0]  kind;
        logic [13:0] cnt;
        logic [10:0] size;
        logic [3:0]  shift;
        logic        bin;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{8'h1F, 16'h2400, 8'h01, 2'd0, 14'd2048, 11'd256,  4'd8,  1'b1}, // R3 R4
        '{8'h1F, 16'h2400, 8'h00, 2'd0, 14'd2048, 11'd264,  4'd9,  1'b0}, // R4
        '{8'h1F, 16'h2600, 8'h01, 2'd0, 14'd4096, 11'd512,  4'd9,  1'b1}, // R4
        '{8'h1F, 16'h2600, 8'h80, 2'd0, 14'd4096, 11'd528,  4'd10, 1'b0}, // R4
        '{8'h1F, 16'h2700, 8'h01, 2'd0, 14'd8192, 11'd528,  4'd10, 1'b0}, // R5
        '{8'h1F, 16'h2701, 8'h01, 2'd0, 14'd8192, 11'd512,  4'd9,  1'b1}, // R3
        '{8'h1F, 16'h2800, 8'h00, 2'd0, 14'd8192, 11'd1056, 4'd11, 1'b0}, // R3
        '{8'h1F, 16'h2200, 8'h01, 2'd0, 14'd512,  11'd256,  4'd8,  1'b1}, // R3
        '{8'h1F, 16'h2900, 8'h01, 2'd1, 14'd0,    11'd0,    4'd0,  1'b0}, // R8
        '{8'hFF, 16'hFFFF, 8'hFF, 2'd2, 14'd0,    11'd0,    4'd0,  1'b0}, // R6
        '{8'h00, 16'h0000, 8'h00, 2'd2, 14'd0,    11'd0,    4'd0,  1'b0}, // R6
        '{8'hFF, 16'hFFFF, 8'h8C, 2'd0, 14'd512,  11'd264,  4'd9,  1'b0}, // R7
        '{8'h00, 16'h0000, 8'h94, 2'd0, 14'd1024, 11'd264,  4'd9,  1'b0}, // R7
        '{8'h00, 16'h0000, 8'h9C, 2'd0, 14'd2048, 11'd264,  4'd9,  1'b0}, // R7
        '{8'h00, 16'h0000, 8'hA4, 2'd0, 14'd4096, 11'd264,  4'd9,  1'b0}, // R7
        '{8'h00, 16'h0000, 8'hAD, 2'd0, 14'd4096, 11'd528,  4'd10, 1'b0}, // R7
        '{8'h00, 16'h0000, 8'hB4, 2'd0, 14'd8192, 11'd528,  4'd10, 1'b0}, // R7
        '{8'h00, 16'h0000, 8'hB8, 2'd0, 14'd8192, 11'd1056, 4'd11, 1'b0}, // R7
        '{8'h00, 16'h0000, 8'hBC, 2'd0, 14'd8192, 11'd1056, 4'd11, 1'b0}, // R7
        '{8'h00, 16'h0000, 8'h90, 2'd1, 14'd0,    11'd0,    4'd0,  1'b0}, // R8
        '{8'h00, 16'h0000, 8'h80, 2'd1, 14'd0,    11'd0,    4'd0,  1'b0}, // R8
        '{8'h1E, 16'h2400, 8'h9C, 2'd0, 14'd2048, 11'd264,  4'd9,  1'b0}  // R7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk, spi_mosi, spi_cs_n;
    logic        spi_miso = 1'b0;
    logic        res_valid, res_unsupported, res_absent;
    logic [13:0] page_count;
    logic [10:0] page_size;
    logic [3:0]  page_shift;
    logic        binary_pages;

    always #2 clk = ~clk;

    flash_geom_probe #(.SCLK_HALF(SCLK_HALF), .CS_GAP(CS_GAP)) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .spi_sclk        (spi_sclk),
        .spi_mosi        (spi_mosi),
        .spi_cs_n        (spi_cs_n),
        .spi_miso        (spi_miso),
        .res_valid       (res_valid),
        .res_unsupported (res_unsupported),
        .res_absent      (res_absent),
        .page_count      (page_count),
        .page_size       (page_size),
        .page_shift      (page_shift),
        .binary_pages    (binary_pages)
    );

    // Flash model contents, set by the stimulus process only.
    logic [7:0] m_vendor = 8'h00, m_hi = 8'h00, m_lo = 8'h00, m_st = 8'h00;

    // Opcode capture on rising sclk; bit counter restarts on chip select fall.
    int         bit_idx = 0;
    logic [7:0] op_sh = 8'h00;
    logic [7:0] op_prev = 8'h00, op_last = 8'h00;
    int         ntx = 0;
    always @(negedge spi_cs_n or posedge spi_sclk) begin
        if (!spi_sclk) begin
            bit_idx = 0;
            op_sh   = 8'h00;
        end else if (!spi_cs_n) begin
            if (bit_idx < 8) op_sh = {op_sh[6:0], spi_mosi};
            bit_idx = bit_idx + 1;
            if (bit_idx == 8) begin
                op_prev = op_last;
                op_last = op_sh;
                ntx     = ntx + 1;
            end
        end
    end

    // Reply bits on falling sclk once the opcode has been taken in.
    always @(negedge spi_sclk) begin
        if (!spi_cs_n && bit_idx >= 8) begin
            automatic int k = bit_idx - 8;
            automatic logic [7:0] b = 8'h00;
            if (op_last == 8'h9F) begin
                if (k / 8 == 0)      b = m_vendor;
                else if (k / 8 == 1) b = m_hi;
                else if (k / 8 == 2) b = m_lo;
            end else if (op_last == 8'hD7) begin
                b = m_st;
            end
            spi_miso = b[7 - (k % 8)];
        end
    end

    // Deselect length seen before each chip select fall.
    int hi_run = 0, last_gap = 0;
    always @(posedge clk) begin
        if (spi_cs_n) hi_run = hi_run + 1;
        else begin
            if (hi_run > 0) last_gap = hi_run;
            hi_run = 0;
        end
    end

    int checks = 0, errs = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int kind_now();
        if (res_valid)       return 0;
        if (res_unsupported) return 1;
        if (res_absent)      return 2;
        return 3;
    endfunction

    task automatic reset_and_check();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R10: outputs idle during reset
        check(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R10", "cs/sclk in reset",
              {spi_cs_n, spi_sclk}, 2);
        check({res_valid, res_unsupported, res_absent} === 3'b000 &&
              page_count === 14'd0 && page_size === 11'd0 &&
              page_shift === 4'd0 && binary_pages === 1'b0,
              "R10", "results in reset", page_size, 0);
        rst_n = 1'b1;
    endtask

    task automatic wait_result(output bit ok);
        ok = 1'b0;
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            if (res_valid | res_unsupported | res_absent) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        bit ok;
        int base;
        m_vendor = v.vendor;
        m_hi     = v.dev[15:8];
        m_lo     = v.dev[7:0];
        m_st     = v.st;
        reset_and_check();
        base = ntx;
        wait_result(ok);
        check(ok, "R9", $sformatf("vec %0d result raised", idx), ok, 1);
        repeat (6) @(negedge clk);
        check(op_prev == 8'h9F && op_last == 8'hD7 && ntx - base == 2,
              "R1", $sformatf("vec %0d opcode order", idx), ntx - base, 2);
        check(last_gap >= CS_GAP, "R2", $sformatf("vec %0d deselect gap", idx),
              last_gap, CS_GAP);
        check(kind_now() == int'(v.kind), (v.kind == 2'd2) ? "R6" :
              (v.kind == 2'd1) ? "R8" : "R3",
              $sformatf("vec %0d result kind", idx), kind_now(), v.kind);
        check(page_count == v.cnt, "R3", $sformatf("vec %0d page count", idx),
              page_count, v.cnt);
        check(page_size == v.size && page_shift == v.shift,
              (v.vendor == 8'h1F) ? "R4" : "R7",
              $sformatf("vec %0d page size", idx), page_size, v.size);
        check(binary_pages == v.bin, (v.dev == 16'h2700) ? "R5" : "R4",
              $sformatf("vec %0d binary flag", idx), binary_pages, v.bin);
    endtask

    initial begin : main
        bit ok;
        int base;
        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R9: no further traffic and stable outputs long after the result.
        base = ntx;
        repeat (600) @(negedge clk);
        check(ntx == base && spi_cs_n === 1'b1, "R9", "no traffic after result",
              ntx - base, 0);
        check(res_unsupported === 1'b0 && res_valid === 1'b1 && page_size == 11'd264,
              "R9", "result held", page_size, 264);

        // R10: reset during the identification read restarts the probe.
        m_vendor = 8'h1F; m_hi = 8'h23; m_lo = 8'h00; m_st = 8'h01;
        reset_and_check();
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(spi_cs_n === 1'b1 && kind_now() == 3, "R10", "abort mid probe",
              spi_cs_n, 1);
        rst_n = 1'b1;
        base = ntx;
        wait_result(ok);
        repeat (6) @(negedge clk);
        check(ok && ntx - base == 2 && op_last == 8'hD7, "R1", "restart transactions",
              ntx - base, 2);
        check(page_count == 14'd1024 && page_size == 11'd256 && page_shift == 4'd8,
              "R4", "restart geometry", page_count, 1024);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule